// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Set-on-Less

This block is a purely combinational arithmetic and logic unit built from identical one-bit slices. A 4-bit control word selects the operation. Its top bit inverts every bit of the first operand before it reaches the slices. Its next bit inverts every bit of the second operand and also supplies the carry into the lowest slice. Its low two bits choose what each slice puts on its result line: the AND of the two conditioned operand bits, their OR, their full-adder sum, or a "less" input.

Only the lowest slice has a live "less" input. It is tied to the sum bit of the most significant slice. With the second operand negated and the less path selected, the result is therefore 1 when the wrapped difference is negative and 0 otherwise, which is the usual set-on-less-than. All sixteen control words are legal and give defined results. This includes the words that a normal instruction decoder never issues: inverted-operand AND and OR, and the less path applied to plain or inverted-operand sums. A zero flag reports an all-zero result.

The block sits in a datapath between the register-read operands and the write-back mux. It has no clock and no state.

Top module: `rip_alu`

## Requirements
- R1: Control bit 3 inverts operand A and control bit 2 inverts operand B before any operation, and control bit 2 is also the carry into bit 0; control bits 1:0 pick the operation.
- R2: With control bits 1:0 = 00 the result is the bitwise AND of the conditioned operands.
- R3: With control bits 1:0 = 01 the result is the bitwise OR of the conditioned operands.
- R4: With control bits 1:0 = 10 the result is (conditioned A + conditioned B + control bit 2) modulo 2^32, so control 0110 gives A - B and 0010 gives A + B.
- R5: With control bits 1:0 = 11 result bit 0 equals bit 31 of the sum R4 would produce for the same inversions, and result bits 31..1 are zero.
- R6: The zero output is 1 exactly when all 32 result bits are 0, for every control word.
- R7: Control 0111 gives result = 1 exactly when bit 31 of the wrapped difference A - B is 1.
- R8: Control 1011 gives result = 1 exactly when bit 31 of (~A + B) modulo 2^32 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| ctrl | input | 4 | {invert A, negate B, operation[1:0]} |
| result | output | 32 | Selected result |
| is_zero | output | 1 | High when result is all zeros |

## Verification
The hardest behaviour to reach is the less path. There, bit 0 depends on a carry that has rippled through all 32 slices, so the sign flips only for operand pairs near the wrap points. Examples are 0x7FFFFFFF against 0x80000000, equal values, and neighbours that differ by one. The stimulus crosses a table of such edge operands with every one of the sixteen control words. It then adds pseudo-random pairs under all sixteen words, so that the undecoded inverted-operand codes meet the same corner operands as the ordinary ones.

// File: rtl/rip_alu_pkg.sv
package rip_alu_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } alu_op_e;

  // one-bit full adder: returns {carry, sum}
  function automatic logic [1:0] bit_add(input logic x, input logic y, input logic c);
    logic s, co;
    s  = x ^ y ^ c;
    co = (x & y) | (x & c) | (y & c);
    return {co, s};
  endfunction

endpackage

// File: rtl/rip_alu_slice.sv
module rip_alu_slice
  import rip_alu_pkg::*;
(
  input  logic    a_in,
  input  logic    b_in,
  input  logic    inv_a,
  input  logic    neg_b,
  input  alu_op_e op,
  input  logic    cin,
  input  logic    less,
  output logic    res,
  output logic    sum,
  output logic    cout
);

  logic a_eff;
  logic b_eff;

  assign a_eff = inv_a ? ~a_in : a_in;
  assign b_eff = neg_b ? ~b_in : b_in;
  assign {cout, sum} = bit_add(a_eff, b_eff, cin);

  always_comb begin
    unique case (op)
      OP_AND:  res = a_eff & b_eff;
      OP_OR:   res = a_eff | b_eff;
      OP_SUM:  res = sum;
      default: res = less;
    endcase
  end

  // R3: an OR result of 0 requires both conditioned inputs low
  always_comb begin
    if (op == OP_OR && !res) begin
      p_or_low_r3: assert (!a_in == !inv_a && !b_in == !neg_b);
    end
  end

endmodule

// File: rtl/rip_alu_zero.sv
module rip_alu_zero #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec,
  output logic             all_clear
);

  localparam int HALF = WIDTH / 2;

  logic lo_any;
  logic hi_any;

  generate
    if (WIDTH > 1) begin : g_split
      assign lo_any = |vec[HALF-1:0];
      assign hi_any = |vec[WIDTH-1:HALF];
    end else begin : g_single
      assign lo_any = vec[0];
      assign hi_any = 1'b0;
    end
  endgenerate

  assign all_clear = ~(lo_any | hi_any);

endmodule

// File: rtl/rip_alu.sv
module rip_alu
  import rip_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             is_zero
);

  localparam int MSB = WIDTH - 1;

  logic    inv_a;
  logic    neg_b;
  alu_op_e op;
  logic    set_w;          // sign of the full-width sum, fed back to bit 0
  logic [WIDTH-1:0] sum_vec;

  assign inv_a = ctrl[3];
  assign neg_b = ctrl[2];
  assign op    = alu_op_e'(ctrl[1:0]);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic c_in_w;
      logic less_w;
      logic res_w;
      logic sum_w;
      logic c_out_w;

      if (i == 0) begin : g_lsb
        assign c_in_w = neg_b;
        assign less_w = set_w;
      end else begin : g_up
        assign c_in_w = g_bit[i-1].c_out_w;
        assign less_w = 1'b0;
      end

      rip_alu_slice u_slice (
        .a_in  (opa[i]),
        .b_in  (opb[i]),
        .inv_a (inv_a),
        .neg_b (neg_b),
        .op    (op),
        .cin   (c_in_w),
        .less  (less_w),
        .res   (res_w),
        .sum   (sum_w),
        .cout  (c_out_w)
      );

      assign result[i]  = res_w;
      assign sum_vec[i] = sum_w;
    end
  endgenerate

  assign set_w = sum_vec[MSB];

  rip_alu_zero #(.WIDTH(WIDTH)) u_zero (
    .vec       (result),
    .all_clear (is_zero)
  );

  // word-level arithmetic restated for the checks below
  logic [WIDTH-1:0] chk_a;
  logic [WIDTH-1:0] chk_b;
  logic [WIDTH-1:0] chk_sum;
  logic [WIDTH-1:0] chk_diff;

  always_comb begin
    chk_a    = inv_a ? ~opa : opa;
    chk_b    = neg_b ? ~opb : opb;
    chk_sum  = chk_a + chk_b + {{MSB{1'b0}}, neg_b};
    chk_diff = opa - opb;

    if (op == OP_AND) begin
      p_and_word_r2: assert (result == (chk_a & chk_b));
    end
    if (op == OP_SUM) begin
      p_ripple_sum_r4: assert (result == chk_sum);
    end
    if (op == OP_LESS) begin
      p_less_upper_r5: assert (result[MSB:1] == '0 && result[0] == chk_sum[MSB]);
    end
    if (ctrl == 4'b0111) begin
      p_slt_sign_r7: assert (result[0] == chk_diff[MSB]);
    end
    p_zero_flag_r6: assert (is_zero == (result == '0));
  end

endmodule

// File: tb/rip_alu_test.sv
module rip_alu_test;

  logic        clk = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [3:0]  ctrl = '0;
  logic [31:0] result;
  logic        is_zero;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  rip_alu uut (
    .opa     (opa),
    .opb     (opb),
    .ctrl    (ctrl),
    .result  (result),
    .is_zero (is_zero)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ctrl=%b a=%h b=%h actual=%h expected=%h", tag, ctrl, opa, opb, act, exp);
    end
  endtask

  // expected output from the requirement text
  function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] ae, be, s;
    ae = c[3] ? ~a : a;                 // R1
    be = c[2] ? ~b : b;
    s  = ae + be + 32'(c[2]);
    case (c[1:0])
      2'b00:   return ae & be;          // R2
      2'b01:   return ae | be;          // R3
      2'b10:   return s;                // R4
      default: return {31'd0, s[31]};   // R5
    endcase
  endfunction

  task automatic apply(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] e;
    logic [31:0] d;
    @(negedge clk);
    ctrl = c; opa = a; opb = b;
    #2;
    e = model(c, a, b);
    case (c[1:0])
      2'b00:   check(c[3] | c[2] ? "R1 R2 and" : "R2 and", result, e);
      2'b01:   check(c[3] | c[2] ? "R1 R3 or"  : "R3 or",  result, e);
      2'b10:   check(c[3] | c[2] ? "R1 R4 sum" : "R4 sum", result, e);
      default: check(c[3] | c[2] ? "R1 R5 less" : "R5 less", result, e);
    endcase
    check("R6 zero", {31'd0, is_zero}, {31'd0, e == 32'd0});
    if (c == 4'b0111) begin
      d = a - b;
      check("R7 slt", result, {31'd0, d[31]});
    end
    if (c == 4'b1011) begin
      d = ~a + b;
      check("R8 inverted-a less", result, {31'd0, d[31]});
    end
  endtask

  logic [31:0] corner [12];

  initial begin
    logic [31:0] seed;
    corner[0]  = 32'h0000_0000; corner[1]  = 32'h0000_0001;
    corner[2]  = 32'hFFFF_FFFF; corner[3]  = 32'h8000_0000;
    corner[4]  = 32'h7FFF_FFFF; corner[5]  = 32'h8000_0001;
    corner[6]  = 32'h7FFF_FFFE; corner[7]  = 32'hFFFF_FFFE;
    corner[8]  = 32'h5555_5555; corner[9]  = 32'hAAAA_AAAA;
    corner[10] = 32'h0000_0002; corner[11] = 32'h1234_5678;

    // state at start: all inputs zero, AND gives zero
    #2;
    check("R2 start result", result, 32'd0);
    check("R6 start zero", {31'd0, is_zero}, 32'd1);

    // directed points
    apply(4'b0110, 32'd5, 32'd5);
    check("R6 equal subtract", {31'd0, is_zero}, 32'd1);
    apply(4'b0111, 32'd3, 32'd7);
    check("R7 3<7", result, 32'd1);
    apply(4'b0111, 32'd7, 32'd3);
    check("R7 7<3", result, 32'd0);
    apply(4'b1011, 32'd4, 32'd4);
    check("R8 ~4+4", result, 32'd1);
    apply(4'b1011, 32'd4, 32'd5);
    check("R8 ~4+5", result, 32'd0);

    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          apply(4'(c), corner[i], corner[j]);

    seed = 32'hC0FF_EE01;
    for (int k = 0; k < 200; k++) begin
      logic [31:0] ra, rb;
      seed = seed * 32'd1664525 + 32'd1013904223; ra = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; rb = seed;
      for (int c = 0; c < 16; c++) apply(4'(c), ra, rb);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule